// File: doc/BRIEF.md
# Multi-cycle 16-bit Teaching Processor

This block is a small stored-program processor in which code and data share one memory. It reads one fixed-length 16-bit instruction word at a time through a single read port. It splits the word into a 4-bit operation code and three 4-bit fields, then carries out the operation. The operation is one of these: a register-to-register arithmetic or logic step, a load of a constant or a memory word into one of sixteen general registers, a program-counter-relative jump, or a stop. Each instruction walks through fetch, a one-cycle memory wait, decode and execute. Loads add a second wait cycle for their data.

The memory port is a plain read strobe with a fixed latency of one cycle. When `mem_rd` is high in a cycle, the word at `mem_addr` must be present on `mem_rdata` during the next cycle. The port has no back-pressure, so the memory can neither stall nor refuse a read. The processor never raises the strobe on two consecutive cycles. The `halted` and `ovf` pins are plain status levels.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous reset clears the program counter, all registers, `ovf` and `halted`. In the first cycle after reset is released, the block strobes a read at address 0.
- R2: An instruction is fetched by strobing its address (the PC). The word is taken from `mem_rdata` one cycle later, and the PC advances by one. Non-load instructions take 4 cycles from fetch to the next fetch. Loads take 5 cycles, and their data read is strobed 3 cycles after the fetch. Reads are never strobed on back-to-back cycles.
- R3: Register operations use destination bits 11:8, first source bits 7:4 and second source bits 3:0. The operation codes are: add 0x7, subtract 0x8 (first minus second), bitwise AND 0x9 and bitwise OR 0xA. Word 0x7123 adds R2 and R3 into R1.
- R4: Opcode 0x3 writes the 8-bit constant in bits 7:0 into the destination register, zero-extended. Opcode 0x1 writes the 8-bit address value in bits 7:0 itself into the register, also zero-extended.
- R5: Opcode 0x2 reads memory at the zero-extended address in bits 7:0 and writes the word into the destination register.
- R6: Opcode 0x4 reads memory at the address formed by adding the base register (bits 7:4) and the unsigned offset in bits 3:0. It writes the word into the destination register.
- R7: Opcode 0x5 reads memory at the address held in the base register (bits 7:4) and writes the word into the destination register.
- R8: Opcode 0x6 copies the source register (bits 7:4) into the destination register (bits 11:8).
- R9: Opcode 0xE adds bits 7:0, taken as a two's-complement offset, to the already-incremented PC. Both forward and backward jumps are supported.
- R10: Opcode 0xF raises `halted`. After that, no further reads are strobed until reset.
- R11: `ovf` is updated by add and subtract only. It is set when the carry into the sign bit differs from the carry out of it, and it keeps its value through every other instruction.
- R12: Opcodes 0x0, 0xB, 0xC and 0xD change no register and take the 4-cycle non-load timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW (16) | Address of the read; meaningful while `mem_rd` is high |
| mem_rd | output | 1 | Read strobe; data is expected on the following cycle |
| mem_rdata | input | DW (16) | Word returned one cycle after the strobe |
| halted | output | 1 | High once a stop instruction has executed |
| ovf | output | 1 | Signed overflow of the most recent add or subtract |

## Verification
The assertions assume a memory that answers every strobe on the next cycle without stalling. They also assume reset is held for at least two clock edges before the first run, so no property reaches back into cycles before reset. The bench memory model is a one-cycle registered array that responds to every strobe. Each program ends in a stop word, and stimulus changes only just after a rising edge. The bench therefore stays inside those assumptions, and it observes register contents only through the read addresses that indirect loads place on `mem_addr`.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int FLD = 4;           // width of each instruction field
  localparam int NREG = 1 << FLD;   // register count addressed by a field
  localparam int IW = 16;           // instruction word width

  localparam logic [3:0] OP_LADR = 4'h1;  // register <= address literal
  localparam logic [3:0] OP_LDIR = 4'h2;  // register <= mem[literal]
  localparam logic [3:0] OP_LIMM = 4'h3;  // register <= constant
  localparam logic [3:0] OP_LIDX = 4'h4;  // register <= mem[base + off]
  localparam logic [3:0] OP_LIND = 4'h5;  // register <= mem[base]
  localparam logic [3:0] OP_COPY = 4'h6;
  localparam logic [3:0] OP_ADD  = 4'h7;
  localparam logic [3:0] OP_SUB  = 4'h8;
  localparam logic [3:0] OP_AND  = 4'h9;
  localparam logic [3:0] OP_OR   = 4'hA;
  localparam logic [3:0] OP_BRA  = 4'hE;
  localparam logic [3:0] OP_STOP = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_EXEC, ST_LWAIT, ST_HALT
  } state_t;

  function automatic logic is_load(input logic [3:0] op);
    return (op == OP_LDIR) || (op == OP_LIDX) || (op == OP_LIND);
  endfunction

  function automatic logic is_alu(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
  endfunction

endpackage

// File: rtl/cpu16_seq.sv
module cpu16_seq
  import cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] op,
  output state_t     st
);

  state_t nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_FETCH:  nxt = ST_FWAIT;
      ST_FWAIT:  nxt = ST_DECODE;
      ST_DECODE: nxt = ST_EXEC;
      ST_EXEC: begin
        if (op == OP_STOP)   nxt = ST_HALT;
        else if (is_load(op)) nxt = ST_LWAIT;
        else                 nxt = ST_FETCH;
      end
      ST_LWAIT:  nxt = ST_FETCH;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else     st <= nxt;
  end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DW = 16,
  parameter int NR = 16,
  localparam int SW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [SW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [SW-1:0] ra1,
  output logic [DW-1:0] rd1
);

  logic [DW-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          ovf
);

  localparam int MSB = DW - 1;

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (op)
      OP_ADD: begin
        y   = a + b;
        ovf = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
      end
      OP_SUB: begin
        y   = a - b;
        ovf = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
      end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic          ovf
);

  state_t        st;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic [DW-1:0] opa, opb;
  logic [DW-1:0] rd0, rd1, alu_y, wd;
  logic          alu_ovf, we;
  logic [AW-1:0] ea;

  logic [3:0]     op;
  logic [FLD-1:0] f_d, f_s, f_t;
  logic [7:0]     lit8;

  assign op   = ir[15:12];
  assign f_d  = ir[11:8];
  assign f_s  = ir[7:4];
  assign f_t  = ir[3:0];
  assign lit8 = ir[7:0];

  cpu16_seq u_seq (.clk(clk), .rst(rst), .op(op), .st(st));

  cpu16_regfile #(.DW(DW), .NR(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wa(f_d), .wd(wd),
    .ra0(f_s), .rd0(rd0), .ra1(f_t), .rd1(rd1)
  );

  cpu16_alu #(.DW(DW)) u_alu (.op(op), .a(opa), .b(opb), .y(alu_y), .ovf(alu_ovf));

  // effective address for the three memory-reading loads
  always_comb begin
    case (op)
      OP_LIDX: ea = AW'(opa) + AW'(f_t);
      OP_LIND: ea = AW'(opa);
      default: ea = AW'(lit8);
    endcase
  end

  assign mem_rd   = (st == ST_FETCH) || ((st == ST_EXEC) && is_load(op));
  assign mem_addr = (st == ST_EXEC) ? ea : pc;
  assign halted   = (st == ST_HALT);

  // register write-back: execute-stage results or returned load data
  always_comb begin
    we = 1'b0;
    wd = alu_y;
    if (st == ST_LWAIT) begin
      we = 1'b1;
      wd = mem_rdata;
    end else if (st == ST_EXEC) begin
      if (op == OP_LADR || op == OP_LIMM) begin
        we = 1'b1;
        wd = DW'(lit8);
      end else if (op == OP_COPY) begin
        we = 1'b1;
        wd = opa;
      end else if (is_alu(op)) begin
        we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      opa <= '0;
      opb <= '0;
      ovf <= 1'b0;
    end else begin
      case (st)
        ST_FETCH:  pc <= pc + AW'(1);
        ST_FWAIT:  ir <= mem_rdata[IW-1:0];
        ST_DECODE: begin
          opa <= rd0;
          opb <= rd1;
        end
        ST_EXEC: begin
          if (op == OP_BRA) pc <= pc + {{(AW-8){lit8[7]}}, lit8};
          if (op == OP_ADD || op == OP_SUB) ovf <= alu_ovf;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          halted,
  input logic          ovf,
  input state_t        st,
  input logic [AW-1:0] pc,
  input logic [3:0]    op,
  input logic [7:0]    off8
);

  // R2: a wait cycle always separates two strobes
  a_r2_no_back2back: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R2: fetch advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH) |=> (pc == $past(pc) + AW'(1)));

  // R9: a jump moves the PC by the signed literal
  a_r9_jump_offset: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && op == OP_BRA) |=> (pc == $past(pc) + AW'($signed($past(off8)))));

  // R10: stop is sticky and silent
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd));

  // R11: overflow moves only out of the execute stage
  a_r11_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (st != ST_EXEC) |=> $stable(ovf));

endmodule

bind cpu16_core cpu16_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .halted(halted), .ovf(ovf),
  .st(st), .pc(pc), .op(ir[15:12]), .off8(ir[7:0])
);

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata = '0;
  logic        halted;
  logic        ovf;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cpu16_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .halted(halted), .ovf(ovf)
  );

  logic [15:0] mem [256];

  // memory model: one cycle read latency, no stall
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  // strobe log, sampled mid-cycle
  logic [15:0] trace [64];
  int          tcyc  [64];
  logic        ovf_at [64];
  int n = 0;
  int cyc = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && n < 64) begin
        trace[n]  = mem_addr;
        tcyc[n]   = cyc;
        ovf_at[n] = ovf;
        n++;
      end
      cyc++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hF000;
  endtask

  task automatic run_prog(input int lim);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 halted clear in reset", int'(halted), 0);
    check("R1 ovf clear in reset", int'(ovf), 0);
    n = 0;
    cyc = 0;
    rst = 1'b0;
    while (!halted && cyc < lim) @(negedge clk);
  endtask

  task automatic t_alu();
    clear_mem();
    mem[0] = 16'h3235;  // R2 = 0x35
    mem[1] = 16'h330C;  // R3 = 0x0C
    mem[2] = 16'h7123;  // R1 = R2 + R3
    mem[3] = 16'h8423;  // R4 = R2 - R3
    mem[4] = 16'h9523;  // R5 = R2 & R3
    mem[5] = 16'hA623;  // R6 = R2 | R3
    mem[6] = 16'h5010;  // probe R1
    mem[7] = 16'h5040;  // probe R4
    mem[8] = 16'h5050;  // probe R5
    mem[9] = 16'h5060;  // probe R6
    mem[10] = 16'hF000;
    run_prog(200);
    check("R1 first strobe address", int'(trace[0]), 0);
    check("R1 first strobe cycle", tcyc[0], 0);
    check("R3 add", int'(trace[7]), 16'h0041);
    check("R3 sub", int'(trace[9]), 16'h0029);
    check("R3 and", int'(trace[11]), 16'h0004);
    check("R3 or", int'(trace[13]), 16'h003D);
    check("R2 fetch cycle of 7th word", tcyc[6], 24);
    check("R2 load strobe cycle", tcyc[7], 27);
    check("R2 fetch after load", tcyc[8], 29);
    check("R2 fetch address after load", int'(trace[8]), 7);
    check("R10 halted", int'(halted), 1);
  endtask

  task automatic t_loads();
    clear_mem();
    mem[0] = 16'h1120;  // R1 = 0x20 literal
    mem[1] = 16'h2240;  // R2 = mem[0x40]
    mem[2] = 16'h4324;  // R3 = mem[R2 + 4]
    mem[3] = 16'h5430;  // R4 = mem[R3]
    mem[4] = 16'h6510;  // R5 = R1
    mem[5] = 16'h5050;  // probe R5
    mem[6] = 16'hF000;
    mem[8'h40] = 16'h0050;
    mem[8'h54] = 16'h0060;
    run_prog(200);
    check("R5 direct load address", int'(trace[2]), 16'h0040);
    check("R6 indexed address from loaded base", int'(trace[4]), 16'h0054);
    check("R7 indirect address from loaded register", int'(trace[6]), 16'h0060);
    check("R8 copy of address literal (R4)", int'(trace[9]), 16'h0020);
  endtask

  task automatic t_jump();
    clear_mem();
    mem[0] = 16'hE002;  // to 3
    mem[1] = 16'h3177;
    mem[2] = 16'h3177;
    mem[3] = 16'h31F0;  // R1 = 0xF0
    mem[4] = 16'h5010;  // probe R1
    mem[5] = 16'hE003;  // to 9
    mem[7] = 16'hF000;
    mem[8] = 16'h3177;
    mem[9] = 16'hE0FD;  // to 7
    run_prog(200);
    check("R9 forward jump target", int'(trace[1]), 3);
    check("R4 constant zero-extended", int'(trace[3]), 16'h00F0);
    check("R9 second forward target", int'(trace[5]), 9);
    check("R9 backward target", int'(trace[6]), 7);
    check("R10 strobes up to stop", n, 7);
    repeat (12) @(negedge clk);
    check("R10 no strobes after stop", n, 7);
    check("R10 stays halted", int'(halted), 1);
  endtask

  task automatic t_ovf();
    clear_mem();
    mem[0] = 16'h2130;  // R1 = 0x7FFF
    mem[1] = 16'h2232;  // R2 = 1
    mem[2] = 16'h7312;  // R3 = R1 + R2 -> overflow
    mem[3] = 16'h6410;  // copy, ovf held
    mem[4] = 16'h7522;  // 1 + 1, no overflow
    mem[5] = 16'h2631;  // R6 = 0x8000
    mem[6] = 16'h8762;  // 0x8000 - 1 -> overflow
    mem[7] = 16'hF000;
    mem[8'h30] = 16'h7FFF;
    mem[8'h31] = 16'h8000;
    mem[8'h32] = 16'h0001;
    run_prog(200);
    check("R11 ovf before add", int'(ovf_at[4]), 0);
    check("R11 add overflow", int'(ovf_at[5]), 1);
    check("R11 held across copy", int'(ovf_at[6]), 1);
    check("R11 cleared by clean add", int'(ovf_at[7]), 0);
    check("R11 sub overflow", int'(ovf_at[10]), 1);
    check("R11 held after stop", int'(ovf), 1);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = 16'h3111;  // R1 = 0x11
    mem[1] = 16'h0155;
    mem[2] = 16'hB1AA;
    mem[3] = 16'hC1FF;
    mem[4] = 16'hD133;
    mem[5] = 16'h5010;  // probe R1
    mem[6] = 16'hF000;
    run_prog(200);
    check("R12 register untouched by unused codes", int'(trace[6]), 16'h0011);
    check("R12 unused codes take 4 cycles", tcyc[5], 20);
    check("R12 fetch order", int'(trace[4]), 4);
  endtask

  initial begin
    clear_mem();
    t_alu();
    t_loads();
    t_jump();
    t_ovf();
    t_nop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule